// File: doc/BRIEF.md
# Banked Interrupt Request Controller

This controller gathers level-sensitive interrupt requests from up to 160 sources, organised as five banks of 32 lines. Every bank keeps a pending register, in which an incoming request is latched until software acknowledges it, and an enable register that decides which pending lines may reach the processor. Each bank drives one interrupt line toward the processor. Bank 0 goes to the first of five consecutive hardware interrupt inputs, and bank 4 goes to the last.

A single read-only vector word packs one 5-bit line index per bank. A dispatcher reads it once and finds, for the bank that interrupted, the lowest-numbered line that is both pending and enabled. In bank 0, lines 0 to 11 are the channels of a DMA engine. They share one enable and one acknowledge, and they are reported as a single source at index 0.

Software reaches the registers through a plain word-addressed port with a write strobe and a read strobe. Read data is registered. This port carries no streaming data, so it has no valid/ready handshake and never applies back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all enable and pending registers read 0, every bank output is low and the vector word reads 0.
- R2: A pending bit is set in any cycle in which its request input is high, whether or not the line is enabled.
- R3: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. If a request and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: Bank output k (irq_o[k]) is high exactly while bank k has at least one bit that is both pending and enabled. It follows the register state with no added delay.
- R5: The vector word holds, for each bank k, in bits 5k+4 to 5k, the lowest index that is both pending and enabled, or 0 when there is none. Bits 31 to 25 read 0.
- R6: In bank 0, lines 0 to 11 form one group. Bit 0 of a write to the bank 0 enable register sets the group enable, and bits 11:0 of that register all read back as the group enable. Writing a 1 to any of pending bits 11:0 clears all twelve. In the vector, any group line reports as index 0.
- R7: The word addresses are: enable of bank k at 2k, pending of bank k at 2k+1, and the vector at 10. Unmapped addresses read 0. Writes to the vector or to unmapped addresses change nothing.
- R8: Read data appears on rdata_o in the cycle after the read strobe and holds until the next read.
- R9: Clearing an enable bit leaves the matching pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 160 | Request lines, bank k at bits 32k+31 to 32k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 5 | Per-bank interrupt lines to the processor |

## Verification
Random sparse request patterns, mixed with random enable writes, acknowledges and reads, are run against a bench model. This separates a correct latch-until-acknowledge behaviour from one that follows the request level, and a correct masking from one that drops pending state. Directed cases cover the following:
- A request and an acknowledge on the same bit in the same cycle, which tells request-wins apart from acknowledge-wins.
- A single bit written in the DMA group, which tells whole-group handling apart from per-line handling.
- Several enabled lines pending together in one bank, which shows whether the vector picks the lowest index rather than the highest.
- Writes to the vector address and to unmapped addresses, which confirm that they change nothing.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_LINES = 32;
  localparam int DMA_GROUP  = 12;
  localparam int ADDR_W     = 4;

  function automatic int en_word(input int bank);
    return 2 * bank;
  endfunction

  function automatic int st_word(input int bank);
    return 2 * bank + 1;
  endfunction

  function automatic int vec_word(input int banks);
    return 2 * banks;
  endfunction
endpackage

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec_in,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        idx_o = IW'(i);
        hit_o = 1'b1;
      end
    end
  end

  // R5: the chosen line is set and no lower line is set
  p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (vec_in[idx_o] && ((vec_in & ((N'(1) << idx_o) - N'(1))) == '0)));
  p_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (idx_o == '0 && vec_in == '0));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int LINES = 32,
  parameter int GROUP = 0,
  parameter int IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             en_we,
  input  logic             st_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] st_q,
  output logic             irq_o,
  output logic [IW-1:0]    vec_o
);
  logic [LINES-1:0] ack_mask;
  logic [LINES-1:0] live;
  logic [IW-1:0]    low_idx;
  logic             low_hit;

  generate
    if (GROUP > 0) begin : g_grouped
      logic                   grp_en;
      logic [LINES-1:GROUP]   line_en;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          grp_en  <= 1'b0;
          line_en <= '0;
        end else if (en_we) begin
          grp_en  <= wdata[0];
          line_en <= wdata[LINES-1:GROUP];
        end
      end
      assign en_q     = {line_en, {GROUP{grp_en}}};
      assign ack_mask = {wdata[LINES-1:GROUP], {GROUP{|wdata[GROUP-1:0]}}};

      // R6: one set bit in the group clears the whole group
      p_grp_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && |wdata[GROUP-1:0] && req_i[GROUP-1:0] == '0)
        |=> st_q[GROUP-1:0] == '0);
    end else begin : g_plain
      logic [LINES-1:0] line_en;
      always_ff @(posedge clk) begin
        if (!rst_n)      line_en <= '0;
        else if (en_we)  line_en <= wdata;
      end
      assign en_q     = line_en;
      assign ack_mask = wdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~(st_we ? ack_mask : '0)) | req_i;
  end

  assign live  = st_q & en_q;
  assign irq_o = |live;

  irq_lowest_enc #(.N(LINES), .IW(IW)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .vec_in (live),
    .idx_o  (low_idx),
    .hit_o  (low_hit)
  );

  always_comb begin
    vec_o = low_idx;
    if (GROUP > 0 && int'(low_idx) < GROUP) vec_o = '0;
  end

  // R2: a request is latched
  p_req_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((st_q & $past(req_i)) == $past(req_i)));
  // R3: full acknowledge with no request empties the bank
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && wdata == '1 && req_i == '0) |=> st_q == '0);
  // R4: disabling every line silences the bank
  p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && wdata == '0) |=> !irq_o);
  // R9: enable writes never drop pending bits
  p_en_keeps_st_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !st_we) |=> ((st_q & $past(st_q)) == $past(st_q)));
  // R4: a set output means the encoder found a live line
  p_irq_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == low_hit);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NB     = NUM_BANKS,
  parameter int LINES  = BANK_LINES,
  parameter int GROUP  = DMA_GROUP,
  parameter int AW     = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB*LINES-1:0] req_i,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [LINES-1:0]    wdata,
  output logic [LINES-1:0]    rdata_o,
  output logic [NB-1:0]       irq_o
);
  localparam int IW = $clog2(LINES);
  localparam int VW = NB * IW;

  logic [LINES-1:0] en_q [NB];
  logic [LINES-1:0] st_q [NB];
  logic [VW-1:0]    vec_all;
  logic [LINES-1:0] rd_mux;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic en_we, st_we;
    assign en_we = wr_en && (addr == AW'(en_word(k)));
    assign st_we = wr_en && (addr == AW'(st_word(k)));
    irq_bank #(
      .LINES (LINES),
      .GROUP ((k == 0) ? GROUP : 0),
      .IW    (IW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_i[k*LINES +: LINES]),
      .en_we (en_we),
      .st_we (st_we),
      .wdata (wdata),
      .en_q  (en_q[k]),
      .st_q  (st_q[k]),
      .irq_o (irq_o[k]),
      .vec_o (vec_all[k*IW +: IW])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr == AW'(en_word(k))) rd_mux = en_q[k];
      if (addr == AW'(st_word(k))) rd_mux = st_q[k];
    end
    if (addr == AW'(vec_word(NB))) rd_mux = LINES'(vec_all);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  // R8: read data holds between reads
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o));
  // R1: outputs come out of reset low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0 && rdata_o == '0));
endmodule

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
  localparam int PERIOD = 10;
  localparam int NB = 5;
  localparam int L  = 32;
  localparam int G  = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NB*L-1:0] req;
  logic            wr_en, rd_en;
  logic [3:0]      addr;
  logic [L-1:0]    wdata;
  logic [L-1:0]    rdata;
  logic [NB-1:0]   irq;

  int n_run  = 0;
  int n_fail = 0;

  logic [L-1:0] m_en [NB];
  logic [L-1:0] m_st [NB];
  logic [L-1:0] m_rd;

  always #(PERIOD/2) clk = ~clk;

  irq_bank_ctrl i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [4:0] m_vec(input int k);
    logic [L-1:0] live;
    live = m_st[k] & m_en[k];
    for (int i = 0; i < L; i++)
      if (live[i]) return (k == 0 && i < G) ? 5'd0 : 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [L-1:0] m_read(input logic [3:0] a);
    logic [L-1:0] v;
    v = '0;
    if (a < 4'd10) v = a[0] ? m_st[a >> 1] : m_en[a >> 1];
    else if (a == 4'd10)
      for (int k = 0; k < NB; k++) v[5*k +: 5] = m_vec(k);
    return v;
  endfunction

  task automatic check(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance model, check outputs
  task automatic cyc(input logic [NB*L-1:0] r, input logic w, input logic rd,
                     input logic [3:0] a, input logic [L-1:0] d, input string tag);
    logic [L-1:0] ack;
    @(negedge clk);
    req = r; wr_en = w; rd_en = rd; addr = a; wdata = d;
    @(posedge clk);
    if (rd) m_rd = m_read(a);
    for (int k = 0; k < NB; k++) begin
      ack = '0;
      if (w && a == 4'(2*k+1)) begin
        ack = d;
        if (k == 0) ack[G-1:0] = {G{|d[G-1:0]}};
      end
      m_st[k] = (m_st[k] & ~ack) | r[k*L +: L];
      if (w && a == 4'(2*k)) begin
        m_en[k] = d;
        if (k == 0) m_en[k][G-1:0] = {G{d[0]}};
      end
    end
    #1;
    check({tag, " R4 irq"}, L'(irq), L'({m_st[4] & m_en[4] ? 1'b1 : 1'b0,
                                          |(m_st[3] & m_en[3]), |(m_st[2] & m_en[2]),
                                          |(m_st[1] & m_en[1]), |(m_st[0] & m_en[0])}));
    if (rd) check({tag, " read"}, rdata, m_rd);
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    cyc('0, 1'b0, 1'b1, a, '0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; req = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    for (int k = 0; k < NB; k++) begin m_en[k] = '0; m_st[k] = '0; end
    m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 irq after reset", L'(irq), '0);
    for (int a = 0; a <= 10; a++) rd_chk(4'(a), "R1 reset regs");

    // R2 latch while disabled
    cyc(160'h1 << 40, 1'b0, 1'b0, 4'd0, '0, "R2 latch");
    rd_chk(4'd3, "R2 pending bit set while disabled");
    // R4 enable shows output
    cyc('0, 1'b1, 1'b0, 4'd2, 32'h0000_0100, "R4 enable bank1");
    // R9 disable keeps pending
    cyc('0, 1'b1, 1'b0, 4'd2, 32'h0, "R9 disable");
    rd_chk(4'd3, "R9 pending kept");
    // R3 write 0 leaves bit, same-cycle request wins
    cyc('0, 1'b1, 1'b0, 4'd3, 32'h0, "R3 write zero");
    rd_chk(4'd3, "R3 zero keeps");
    cyc(160'h1 << 40, 1'b1, 1'b0, 4'd3, 32'h100, "R3 request beats ack");
    rd_chk(4'd3, "R3 request wins");
    cyc('0, 1'b1, 1'b0, 4'd3, 32'h100, "R3 ack");
    rd_chk(4'd3, "R3 cleared");

    // R6 group enable, readback, vector collapse, group ack
    cyc('0, 1'b1, 1'b0, 4'd0, 32'h8000_0001, "R6 group enable");
    rd_chk(4'd0, "R6 group enable readback");
    cyc(160'h0000_0220, 1'b0, 1'b0, 4'd0, '0, "R6 group request");
    rd_chk(4'd10, "R6 vector group index 0");
    cyc('0, 1'b1, 1'b0, 4'd1, 32'h0000_0004, "R6 group ack");
    rd_chk(4'd1, "R6 group cleared");

    // R5 lowest index wins in bank 2
    cyc('0, 1'b1, 1'b0, 4'd4, 32'hFFFF_FFFF, "R5 enable bank2");
    cyc(160'h8010_0800 << 64, 1'b0, 1'b0, 4'd0, '0, "R5 multi pending");
    rd_chk(4'd10, "R5 vector lowest");
    // R7 writes to vector / unmapped ignored
    cyc('0, 1'b1, 1'b0, 4'd10, 32'hFFFF_FFFF, "R7 vector write");
    cyc('0, 1'b1, 1'b0, 4'd13, 32'hFFFF_FFFF, "R7 unmapped write");
    rd_chk(4'd10, "R7 vector unchanged");
    rd_chk(4'd13, "R7 unmapped reads 0");
    for (int a = 0; a < 10; a++) rd_chk(4'(a), "R7 regs unchanged");
    // R8 rdata holds without read strobe
    cyc('0, 1'b1, 1'b0, 4'd5, 32'hFFFF_FFFF, "R8 no read");
    check("R8 rdata held", rdata, m_rd);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [NB*L-1:0] r;
      logic [3:0] a;
      for (int k = 0; k < NB; k++) r[k*L +: L] = $urandom & $urandom & $urandom & $urandom;
      a = 4'($urandom_range(0, 11));
      cyc(($urandom % 4 == 0) ? r : '0, ($urandom % 2) == 0, ($urandom % 2) == 0, a,
          ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom, "R5 random");
    end
    for (int a = 0; a <= 10; a++) rd_chk(4'(a), "R5 final regs");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule